// File: doc/BRIEF.md
# Four-Tap Polyphase Horizontal Line Scaler

The block resamples one video line of 10-bit pixels to a new width. A fixed-point position accumulator starts at zero for each line and advances by a programmable step for every output pixel. The step has an integer part and 24 fraction bits. Its integer part selects a four-pixel window of the input. The top six fraction bits select one of 64 filter phases. Each output is a weighted sum of four input pixels. It is normalised by a 9-bit shift, rounded and clamped.

Pixels arrive on a valid/ready stream. The block raises input ready only while it still needs pixels for the next output. Results leave on a second valid/ready stream, and the last pixel of each line is flagged. Only half a period of phases is stored: 33 rows of four signed taps with a gain of 512. The phases above the half-pixel point are formed by reading a mirrored row with its taps in reverse order. Software may overwrite the rows through a small write port.

The block passes input straight through when it is disabled or when the output width equals the input width.

Top module: `hpoly_scaler`

## Requirements
- R1: After reset the output stream is idle. Each row r of the coefficient bank holds the linear pair {0, 512-8r, 8r, 0}, listed as taps 0 to 3.
- R2: When `en` is low, or when `out_width` equals `in_width`, every input pixel appears unchanged on the output. The handshakes pass through, and `m_last` marks pixel number `in_width` of the line.
- R3: In scaling mode a line of `in_width` inputs yields exactly `out_width` outputs, with `m_last` on the final one only. Input pixels beyond those the filter needs are accepted and dropped. The next line then starts from position zero.
- R4: Output j sits at x = j*step with 24 fraction bits, and its integer part i = x>>24. Its taps read input pixels i-1, i, i+1 and i+2 in that order. Any index outside 0 to in_width-1 is replaced by the nearest valid pixel.
- R5: The phase p is bits [23:18] of x. For p from 0 to 32, row p is used as stored. For p above 32, row 64-p is used with its four taps reversed.
- R6: The output is computed in three steps. First the signed sum of tap times pixel is formed. Then 256 is added and the result is shifted right arithmetically by 9. Finally it is clamped to the range 0 to 1023.
- R7: A coefficient write with `coef_cmd`=0 sets the load pointer to row 0. Each write with `coef_cmd`=1 stores two taps, taking `coef_data[10:0]` first and `coef_data[21:11]` second. The first write for a row fills taps 0 and 1, and the second fills taps 2 and 3 and moves to the next row. Pair writes after row 32 is complete change nothing.
- R8: While an output is held with `m_ready` low, `m_valid` and `m_data` stay unchanged. Input is not accepted while the window already holds every pixel the next output needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Scaling enable; low selects pass-through |
| in_width | input | 12 | Input pixels per line (at least 4) |
| out_width | input | 12 | Output pixels per line (at least 1) |
| step | input | 36 | Position increment, 12 integer and 24 fraction bits |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_data | input | 10 | Input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 10 | Output pixel |
| m_last | output | 1 | Last output pixel of the line |
| coef_wr | input | 1 | Coefficient port write strobe |
| coef_cmd | input | 1 | 0 resets the load pointer, 1 writes a tap pair |
| coef_data | input | 22 | Two signed 11-bit taps |

## Verification
A window that advances one pixel too far or too few shows up in the very next output of the line as a value taken from a shifted neighbourhood. This is clearest on ramps and hard edges, where every neighbour has a different value. A wrong phase or an unreversed mirror leaves outputs below the half-pixel point correct and corrupts only the upper half. For that reason the checks use non-symmetric tables and irregular steps. A load pointer that goes wrong stays hidden until the next scaled line, so a line is always run after the table is loaded. A miscount of outputs or inputs shows as a misplaced last flag or a stalled stream on that same line.

// File: rtl/hpoly_pkg.sv
package hpoly_pkg;

  typedef enum logic {
    CMD_INDEX = 1'b0,
    CMD_PAIR  = 1'b1
  } coef_cmd_e;

  // Reset contents: linear interpolation over half a pixel period.
  function automatic int lin_tap(int row, int k, int phb, int norm);
    int frac_w;
    frac_w = (row << norm) >> phb;
    case (k)
      1:       return (1 << norm) - frac_w;
      2:       return frac_w;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hpoly_coef_bank.sv
module hpoly_coef_bank #(
  parameter int CW   = 11,
  parameter int PHB  = 6,
  parameter int NORM = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_cmd,
  input  logic [2*CW-1:0]      wr_data,
  input  logic [PHB-1:0]       phase,
  output logic [3:0][CW-1:0]   taps
);
  import hpoly_pkg::*;

  localparam int HALF = 1 << (PHB - 1);
  localparam int ROWS = HALF + 1;
  localparam int PTRW = $clog2(ROWS + 1);
  localparam logic [PHB:0] FULL = (PHB + 1)'(1 << PHB);

  logic [CW-1:0]   tbl_q [ROWS][4];
  logic [PTRW-1:0] ptr_q, ptr_d;
  logic            half_q, half_d;
  logic            wr_idx, wr_pair, row_ok;
  logic            flip;
  logic [PHB:0]    mir;
  logic [PHB-1:0]  row_sel;

  // load pointer: next state
  always_comb begin
    wr_idx  = wr_en && (coef_cmd_e'(wr_cmd) == CMD_INDEX);
    wr_pair = wr_en && (coef_cmd_e'(wr_cmd) == CMD_PAIR);
    row_ok  = ptr_q < PTRW'(ROWS);
    ptr_d   = ptr_q;
    half_d  = half_q;
    if (wr_idx) begin
      ptr_d  = '0;
      half_d = 1'b0;
    end else if (wr_pair && row_ok) begin
      if (half_q) begin
        half_d = 1'b0;
        ptr_d  = ptr_q + PTRW'(1);
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      half_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      half_q <= half_d;
    end
  end

  // tap storage with per-row write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < 4; k++)
          tbl_q[r][k] <= CW'(lin_tap(r, k, PHB, NORM));
    end else if (wr_pair && row_ok) begin
      for (int r = 0; r < ROWS; r++) begin
        if (ptr_q == PTRW'(r)) begin
          if (half_q) begin
            tbl_q[r][2] <= wr_data[CW-1:0];
            tbl_q[r][3] <= wr_data[2*CW-1:CW];
          end else begin
            tbl_q[r][0] <= wr_data[CW-1:0];
            tbl_q[r][1] <= wr_data[2*CW-1:CW];
          end
        end
      end
    end
  end

  // phase read: upper half mirrors a stored row
  always_comb begin
    flip    = phase > PHB'(HALF);
    mir     = FULL - {1'b0, phase};
    row_sel = flip ? mir[PHB-1:0] : phase;
    for (int k = 0; k < 4; k++)
      taps[k] = flip ? tbl_q[row_sel][3-k] : tbl_q[row_sel][k];
  end

  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (ptr_q == '0) && !half_q);  // R7

  AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pair && !row_ok) |=> $stable(tbl_q[ROWS-1][3]) && $stable(tbl_q[0][1]));  // R7

endmodule

// File: rtl/hpoly_window.sv
module hpoly_window #(
  parameter int W  = 12,
  parameter int PW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 clr,
  input  logic [PW-1:0]        din,
  input  logic [W-1:0]         in_width,
  input  logic [W-1:0]         center,
  output logic [W-1:0]         rcv,
  output logic [3:0][PW-1:0]   px
);

  localparam int SW = W + 3;

  logic [3:0][PW-1:0] win_q;
  logic [W-1:0]       rcv_q, rcv_d;
  logic signed [SW-1:0] base_c, hi, idx, off;

  always_comb begin
    rcv_d = rcv_q;
    if (clr)       rcv_d = '0;
    else if (take) rcv_d = rcv_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q <= '0;
      win_q <= '0;
    end else begin
      rcv_q <= rcv_d;
      if (take) win_q <= {din, win_q[3:1]};
    end
  end

  assign rcv = rcv_q;

  // win_q[0] holds pixel rcv-4, win_q[3] holds pixel rcv-1
  always_comb begin
    base_c = $signed({3'b000, center});
    hi     = $signed({3'b000, in_width}) - SW'(1);
    idx    = '0;
    off    = '0;
    for (int k = 0; k < 4; k++) begin
      idx = base_c + SW'(k) - SW'(1);
      if (idx < 0)       idx = '0;
      else if (idx > hi) idx = hi;
      off   = idx - $signed({3'b000, rcv_q}) + SW'(4);
      px[k] = win_q[off[1:0]];
    end
  end

  AST_RCV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_q <= in_width);  // R3

endmodule

// File: rtl/hpoly_mac.sv
module hpoly_mac #(
  parameter int PW   = 10,
  parameter int CW   = 11,
  parameter int NORM = 9
) (
  input  logic [3:0][PW-1:0] pix,
  input  logic [3:0][CW-1:0] taps,
  output logic [PW-1:0]      y
);

  localparam int SW   = PW + CW + 3;
  localparam int MAXV = (1 << PW) - 1;

  logic signed [SW-1:0] sum, rnd;

  always_comb begin
    sum = '0;
    for (int k = 0; k < 4; k++)
      sum = sum + ($signed({1'b0, pix[k]}) * $signed(taps[k]));
    rnd = (sum + $signed(SW'(1 << (NORM - 1)))) >>> NORM;
    if (rnd < 0)                          y = '0;
    else if (rnd > $signed(SW'(MAXV)))    y = PW'(MAXV);
    else                                  y = rnd[PW-1:0];
  end

endmodule

// File: rtl/hpoly_scaler.sv
module hpoly_scaler #(
  parameter int W    = 12,
  parameter int PW   = 10,
  parameter int CW   = 11,
  parameter int PHB  = 6,
  parameter int NORM = 9,
  parameter int FRAC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [W-1:0]      in_width,
  input  logic [W-1:0]      out_width,
  input  logic [W+FRAC-1:0] step,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PW-1:0]     s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PW-1:0]     m_data,
  output logic              m_last,
  input  logic              coef_wr,
  input  logic              coef_cmd,
  input  logic [2*CW-1:0]   coef_data
);

  localparam int AW = W + FRAC;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [AW-1:0]      acc_q, acc_d;
  logic [W-1:0]       ocnt_q, ocnt_d;
  logic               ov_q, ov_d, ol_q, ol_d;
  logic [PW-1:0]      od_q, od_d;
  logic [W-1:0]       rcv, ctr;
  logic [PHB-1:0]     phase;
  logic [W:0]         ip3, need;
  logic               bypass, done, have, line_clr, take, prod;
  logic [3:0][PW-1:0] px;
  logic [3:0][CW-1:0] taps;
  logic [PW-1:0]      fy;

  assign ctr   = acc_q[AW-1:FRAC];
  assign phase = acc_q[FRAC-1 -: PHB];

  hpoly_window #(.W(W), .PW(PW)) u_win (
    .clk(clk), .rst_n(rst_i_n), .take(take), .clr(line_clr), .din(s_data),
    .in_width(in_width), .center(ctr), .rcv(rcv), .px(px)
  );

  hpoly_coef_bank #(.CW(CW), .PHB(PHB), .NORM(NORM)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_en(coef_wr), .wr_cmd(coef_cmd),
    .wr_data(coef_data), .phase(phase), .taps(taps)
  );

  hpoly_mac #(.PW(PW), .CW(CW), .NORM(NORM)) u_mac (
    .pix(px), .taps(taps), .y(fy)
  );

  // flow decisions
  always_comb begin
    bypass   = !en || (out_width == in_width);
    done     = ocnt_q == out_width;
    ip3      = {1'b0, ctr} + (W + 1)'(3);
    need     = (ip3 > {1'b0, in_width}) ? {1'b0, in_width} : ip3;
    have     = {1'b0, rcv} >= need;
    line_clr = (rcv == in_width) && (bypass || done);
    if (bypass) s_ready = m_ready && (rcv < in_width);
    else        s_ready = (rcv < in_width) && (done || !have);
    take     = s_valid && s_ready;
    prod     = !bypass && !done && have && (!ov_q || m_ready);
  end

  // next state
  always_comb begin
    acc_d  = acc_q;
    ocnt_d = ocnt_q;
    ov_d   = ov_q;
    od_d   = od_q;
    ol_d   = ol_q;
    if (line_clr) begin
      acc_d  = '0;
      ocnt_d = '0;
    end else if (prod) begin
      acc_d  = acc_q + step;
      ocnt_d = ocnt_q + W'(1);
    end
    if (prod) begin
      ov_d = 1'b1;
      od_d = fy;
      ol_d = (ocnt_q == out_width - W'(1));
    end else if (m_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_q  <= '0;
      ocnt_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      ol_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      ocnt_q <= ocnt_d;
      ov_q   <= ov_d;
      od_q   <= od_d;
      ol_q   <= ol_d;
    end
  end

  assign m_valid = bypass ? (s_valid && (rcv < in_width)) : ov_q;
  assign m_data  = bypass ? s_data : od_q;
  assign m_last  = bypass ? (rcv == in_width - W'(1)) : ol_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!bypass && ov_q && !m_ready) |=> (ov_q && $stable(od_q) && $stable(ol_q)));  // R8

  AST_OCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_i_n)
    ocnt_q <= out_width);  // R3

endmodule

// File: tb/hpoly_scaler_test.sv
`timescale 1ns/1ps
module hpoly_scaler_test;

  logic        clk, rst_n, en;
  logic [11:0] in_width, out_width;
  logic [35:0] step;
  logic        s_valid, s_ready, m_valid, m_ready, m_last;
  logic [9:0]  s_data, m_data;
  logic        coef_wr, coef_cmd;
  logic [21:0] coef_data;

  hpoly_scaler uut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_width(in_width), .out_width(out_width),
    .step(step), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .coef_wr(coef_wr), .coef_cmd(coef_cmd), .coef_data(coef_data)
  );

  typedef struct packed { logic [9:0] d; logic l; } exp_t;
  exp_t  exp_q[$];
  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  int    tbl [33][4];
  int    line_px [256];
  int    bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int    cycles = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = (bp_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  // monitor: compares every transfer with the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected output pixel", int'(m_data), -1);
      end else begin
        e = exp_q.pop_front();
        chk(m_data == e.d, "pixel value", int'(m_data), int'(e.d));
        chk(m_last == e.l, "R3 last flag", int'(m_last), int'(e.l));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8: actual %0d expected %0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int ref_px(int in_w, longint st, int j);
    longint x;
    int i, ph, idx, s;
    int c [4];
    x  = longint'(j) * st;
    i  = int'(x >> 24);
    ph = int'((x >> 18) & 63);
    for (int k = 0; k < 4; k++)
      c[k] = (ph <= 32) ? tbl[ph][k] : tbl[64 - ph][3 - k];
    s = 0;
    for (int k = 0; k < 4; k++) begin
      idx = i - 1 + k;
      if (idx < 0) idx = 0;
      if (idx > in_w - 1) idx = in_w - 1;
      s += c[k] * line_px[idx];
    end
    s = (s + 256) >>> 9;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic coef_write(bit cmd, int a, int b);
    @(posedge clk); #1;
    coef_wr   = 1'b1;
    coef_cmd  = cmd;
    coef_data = {b[10:0], a[10:0]};
    @(posedge clk); #1;
    coef_wr   = 1'b0;
  endtask

  task automatic load_formula();
    int n;
    coef_write(1'b1, 999, -999);        // stray pair, overwritten below
    coef_write(1'b0, 0, 0);             // pointer back to row 0
    for (int r = 0; r <= 32; r++) begin
      n = (r * (32 - r)) >> 4;
      tbl[r][0] = -n;
      tbl[r][1] = 512 - 8 * r + n;
      tbl[r][2] = 8 * r + n;
      tbl[r][3] = -n;
      coef_write(1'b1, tbl[r][0], tbl[r][1]);
      coef_write(1'b1, tbl[r][2], tbl[r][3]);
    end
    coef_write(1'b1, 300, -300);        // past the last row: ignored
    coef_write(1'b1, -5, 700);
  endtask

  task automatic run_line(int in_w, int out_w, bit en_v, int kind, string t);
    longint st;
    exp_t e;
    int t_out;
    tag = t;
    st  = ((longint'(in_w) << 12) / out_w) << 12;
    en        = en_v;
    in_width  = in_w[11:0];
    out_width = out_w[11:0];
    step      = st[35:0];
    for (int k = 0; k < in_w; k++) begin
      case (kind)
        0: line_px[k] = (k * 1023) / (in_w - 1);
        1: line_px[k] = (k < in_w / 2) ? 0 : 1023;
        default: line_px[k] = int'(lfsr[9:0] ^ 10'(k * 37));
      endcase
    end
    if (!en_v || in_w == out_w) begin
      for (int k = 0; k < in_w; k++) begin
        e.d = line_px[k][9:0];
        e.l = (k == in_w - 1);
        exp_q.push_back(e);
      end
    end else begin
      for (int j = 0; j < out_w; j++) begin
        e.d = 10'(ref_px(in_w, st, j));
        e.l = (j == out_w - 1);
        exp_q.push_back(e);
      end
    end
    for (int k = 0; k < in_w; k++) begin
      s_valid = 1'b1;
      s_data  = line_px[k][9:0];
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1;
      s_valid = 1'b0;
      if (bp_mode != 0 && lfsr[5]) begin
        @(posedge clk); #1;
      end
    end
    t_out = 0;
    while (exp_q.size() != 0 && t_out < 5000) begin
      @(posedge clk);
      t_out++;
    end
    #1;
    chk(exp_q.size() == 0, "R3 outputs missing at line end", exp_q.size(), 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; in_width = 12'd16; out_width = 12'd16;
    step = 36'h1000000; s_valid = 1'b0; s_data = '0;
    coef_wr = 1'b0; coef_cmd = 1'b0; coef_data = '0; m_ready = 1'b1;
    for (int r = 0; r <= 32; r++) begin
      tbl[r][0] = 0; tbl[r][1] = 512 - 8 * r; tbl[r][2] = 8 * r; tbl[r][3] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tag = "R1 reset";
    chk(m_valid == 1'b0, "output idle after reset", int'(m_valid), 0);
    chk(s_ready == 1'b1, "R2 input ready in pass-through", int'(s_ready), 1);
    @(posedge clk); #1;

    run_line(16, 16, 1'b0, 0, "R2 disabled pass-through");
    run_line(20, 20, 1'b1, 2, "R2 equal widths pass-through");
    run_line(16, 24, 1'b1, 0, "R1 R4 R5 R6 default table upscale");
    run_line(32, 12, 1'b1, 2, "R4 R5 R6 downscale");
    run_line(40, 8,  1'b1, 0, "R3 R4 large step downscale");
    load_formula();
    run_line(10, 37, 1'b1, 1, "R7 R6 R5 loaded table clamp");
    run_line(33, 19, 1'b1, 2, "R7 R5 loaded table random");
    bp_mode = 1;
    run_line(12, 29, 1'b1, 2, "R8 backpressure upscale");
    run_line(30, 7,  1'b1, 1, "R8 R3 backpressure downscale");
    run_line(24, 15, 1'b1, 0, "R3 consecutive line one");
    run_line(24, 15, 1'b1, 2, "R3 consecutive line two");
    run_line(18, 18, 1'b0, 2, "R2 R8 pass-through backpressure");
    bp_mode = 0;
    run_line(17, 5,  1'b1, 1, "R4 edge replication");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule